// File: doc/BRIEF.md
# Receive Header Strip and Token Insert

This block sits between the acceptance filter of an asynchronous receive path and the receive buffer. Each accepted packet arrives as a stream of 32-bit quadlets framed by start and end markers. The first three quadlets are always header quadlets. A fourth quadlet is present only for quadlet-sized transactions that carry a payload. The block can put a link-generated control token quadlet in front of the packet. It can also remove any of the four header quadlet positions. The result leaves as a stream with valid, ready and last signals.

Software-facing configuration is two plain inputs: one insert enable and a four-bit strip mask. Both are taken from the ports on the first quadlet of a packet and held until that packet ends. The transaction code sits in bits 7:4 of header quadlet 0. It decides whether a fourth quadlet follows, and it is copied into the token. The output is a single registered stage with full-rate throughput. The input is stalled for exactly one handshake slot while a token is produced.

Top module: `rxhs_strip_insert`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, out_valid is low.
- R2: When the insert enable is set, the token quadlet is emitted before anything else of the packet. in_ready is low while the first quadlet is offered and the token has not yet been produced.
- R3: The token quadlet holds the transaction code (header quadlet 0 bits 7:4) in bits 3:0 and in_ack (sampled with the first quadlet) in bits 7:4. All higher bits are zero.
- R4: Header quadlet position j (0..3) is discarded when cfg_strip[j] is 1. Kept quadlets leave unchanged and in arrival order.
- R5: Transaction codes 0 (quadlet write request) and 6 (quadlet read response) make a four-quadlet packet. Every other code makes a three-quadlet packet, and for those cfg_strip[3] has no effect.
- R6: out_last is high on exactly the final quadlet emitted for a packet, whether that is the token or a header quadlet. A packet with no token and every present quadlet stripped emits nothing.
- R7: While out_valid is high and out_ready is low, out_data and out_last hold and in_ready is low. No quadlet is lost or duplicated under any backpressure pattern.
- R8: cfg_insert and cfg_strip are used only as sampled with the first quadlet. Changing them later in the packet has no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_insert | input | 1 | Prepend a token quadlet to each packet |
| cfg_strip | input | 4 | Bit j discards header quadlet position j |
| in_valid | input | 1 | Input quadlet valid |
| in_ready | output | 1 | Input quadlet accepted when high with in_valid |
| in_data | input | 32 | Input quadlet |
| in_sop | input | 1 | First quadlet of a packet |
| in_eop | input | 1 | Final quadlet of a packet |
| in_ack | input | 4 | Acknowledge/error code, valid with the first quadlet |
| out_valid | output | 1 | Output quadlet valid |
| out_ready | input | 1 | Downstream can take a quadlet |
| out_data | output | 32 | Output quadlet |
| out_last | output | 1 | Final emitted quadlet of the packet |

## Verification
The bench sweeps every combination of insert enable, strip mask and the four quadlet transaction codes, both with the output always ready and with a pseudo-random stall pattern. A design that tied out_last to the input end marker would miss packets whose tail was stripped, and would flag the token wrongly when every header was removed. A design that derived packet length from the wrong code would add or drop the payload quadlet. A design that let the input through during token generation would lose or reorder header quadlet 0. Configuration inputs are inverted straight after the first quadlet is taken, so re-reading them mid-packet changes the observed stream.

// File: rtl/rxhs_pkg.sv
package rxhs_pkg;
  localparam int DEF_QUAD_W    = 32;
  localparam int DEF_HDR_Q     = 4;
  localparam int DEF_TCODE_W   = 4;
  localparam int DEF_ACK_W     = 4;
  localparam int DEF_TCODE_LSB = 4;

  // transaction codes whose packets carry a payload quadlet
  localparam logic [DEF_TCODE_W-1:0] TC_QUAD_WRITE_REQ = 4'h0;
  localparam logic [DEF_TCODE_W-1:0] TC_QUAD_READ_RESP = 4'h6;
endpackage

// File: rtl/rxhs_tcode_len.sv
module rxhs_tcode_len
  import rxhs_pkg::*;
#(
  parameter int HDR_Q   = DEF_HDR_Q,
  parameter int TCODE_W = DEF_TCODE_W,
  localparam int CNT_W  = $clog2(HDR_Q + 1)
) (
  input  logic [TCODE_W-1:0] tcode,
  output logic [CNT_W-1:0]   quad_count
);
  logic has_payload;

  always_comb begin
    has_payload = (tcode == TCODE_W'(TC_QUAD_WRITE_REQ)) ||
                  (tcode == TCODE_W'(TC_QUAD_READ_RESP));
    quad_count  = has_payload ? CNT_W'(HDR_Q) : CNT_W'(HDR_Q - 1);
  end
endmodule

// File: rtl/rxhs_last_calc.sv
module rxhs_last_calc #(
  parameter int HDR_Q  = 4,
  localparam int IDX_W = $clog2(HDR_Q),
  localparam int CNT_W = $clog2(HDR_Q + 1)
) (
  input  logic [HDR_Q-1:0] strip,
  input  logic [CNT_W-1:0] quad_count,
  input  logic [IDX_W-1:0] pos,
  input  logic             for_token,
  output logic             is_last
);
  logic [HDR_Q-1:0] later_kept;

  // a position is "later and kept" when it exists in this packet, is not
  // stripped and follows the quadlet being emitted
  for (genvar j = 0; j < HDR_Q; j++) begin : g_pos
    assign later_kept[j] = (CNT_W'(j) < quad_count) && !strip[j] &&
                           (for_token || (IDX_W'(j) > pos));
  end

  assign is_last = ~|later_kept;
endmodule

// File: rtl/rxhs_token_gen.sv
module rxhs_token_gen
  import rxhs_pkg::*;
#(
  parameter int QUAD_W  = DEF_QUAD_W,
  parameter int TCODE_W = DEF_TCODE_W,
  parameter int ACK_W   = DEF_ACK_W,
  localparam int PAD_W  = QUAD_W - ACK_W - TCODE_W
) (
  input  logic [TCODE_W-1:0] tcode,
  input  logic [ACK_W-1:0]   ack,
  output logic [QUAD_W-1:0]  token
);
  assign token = {{PAD_W{1'b0}}, ack, tcode};
endmodule

// File: rtl/rxhs_strip_insert.sv
module rxhs_strip_insert
  import rxhs_pkg::*;
#(
  parameter int QUAD_W    = DEF_QUAD_W,
  parameter int HDR_Q     = DEF_HDR_Q,
  parameter int TCODE_W   = DEF_TCODE_W,
  parameter int ACK_W     = DEF_ACK_W,
  parameter int TCODE_LSB = DEF_TCODE_LSB,
  localparam int IDX_W    = $clog2(HDR_Q),
  localparam int CNT_W    = $clog2(HDR_Q + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_insert,
  input  logic [HDR_Q-1:0]  cfg_strip,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [QUAD_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [ACK_W-1:0]  in_ack,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [QUAD_W-1:0] out_data,
  output logic              out_last
);
  // per-packet state
  logic [IDX_W-1:0]   idx_q;
  logic               tok_done_q;
  logic [HDR_Q-1:0]   strip_q;
  logic [TCODE_W-1:0] tcode_q;

  // output register
  logic               out_valid_q;
  logic [QUAD_W-1:0]  out_data_q;
  logic               out_last_q;

  // current-quadlet view: live config on the first quadlet, latched later
  logic [IDX_W-1:0]   cur_idx;
  logic [HDR_Q-1:0]   strip_cur;
  logic [TCODE_W-1:0] tcode_cur;
  logic [CNT_W-1:0]   count_cur;
  logic               can_load;
  logic               tok_pending;
  logic               accept;
  logic               keep_cur;
  logic               last_hdr;
  logic               last_tok;
  logic [QUAD_W-1:0]  token;

  assign cur_idx   = in_sop ? '0 : idx_q;
  assign strip_cur = in_sop ? cfg_strip : strip_q;
  assign tcode_cur = in_sop ? in_data[TCODE_LSB +: TCODE_W] : tcode_q;

  rxhs_tcode_len #(
    .HDR_Q   (HDR_Q),
    .TCODE_W (TCODE_W)
  ) u_len (
    .tcode      (tcode_cur),
    .quad_count (count_cur)
  );

  rxhs_last_calc #(
    .HDR_Q (HDR_Q)
  ) u_last_hdr (
    .strip      (strip_cur),
    .quad_count (count_cur),
    .pos        (cur_idx),
    .for_token  (1'b0),
    .is_last    (last_hdr)
  );

  rxhs_last_calc #(
    .HDR_Q (HDR_Q)
  ) u_last_tok (
    .strip      (strip_cur),
    .quad_count (count_cur),
    .pos        (cur_idx),
    .for_token  (1'b1),
    .is_last    (last_tok)
  );

  rxhs_token_gen #(
    .QUAD_W  (QUAD_W),
    .TCODE_W (TCODE_W),
    .ACK_W   (ACK_W)
  ) u_tok (
    .tcode (tcode_cur),
    .ack   (in_ack),
    .token (token)
  );

  assign can_load    = !out_valid_q || out_ready;
  assign tok_pending = in_valid && in_sop && cfg_insert && !tok_done_q;
  assign in_ready    = can_load && !tok_pending;
  assign accept      = in_valid && in_ready;
  assign keep_cur    = !strip_cur[cur_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q       <= '0;
      tok_done_q  <= 1'b0;
      strip_q     <= '0;
      tcode_q     <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_last_q  <= 1'b0;
    end else if (tok_pending && can_load) begin
      out_valid_q <= 1'b1;
      out_data_q  <= token;
      out_last_q  <= last_tok;
      tok_done_q  <= 1'b1;
    end else if (accept) begin
      if (keep_cur) begin
        out_valid_q <= 1'b1;
        out_data_q  <= in_data;
        out_last_q  <= last_hdr;
      end else begin
        out_valid_q <= 1'b0;
      end
      if (in_sop) begin
        strip_q <= cfg_strip;
        tcode_q <= in_data[TCODE_LSB +: TCODE_W];
      end
      if (in_eop) begin
        idx_q      <= '0;
        tok_done_q <= 1'b0;
      end else begin
        idx_q <= cur_idx + 1'b1;
      end
    end else if (can_load) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_last  = out_last_q;
endmodule

// File: rtl/rxhs_strip_insert_chk.sv
module rxhs_strip_insert_chk #(
  parameter int QUAD_W = 32,
  parameter int HDR_Q  = 4,
  parameter int TOK_W  = 8,
  localparam int IDX_W = $clog2(HDR_Q)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_insert,
  input logic              in_valid,
  input logic              in_ready,
  input logic [QUAD_W-1:0] in_data,
  input logic              in_sop,
  input logic              out_valid,
  input logic              out_ready,
  input logic [QUAD_W-1:0] out_data,
  input logic              out_last,
  input logic              tok_done_q,
  input logic [IDX_W-1:0]  idx_q,
  input logic [HDR_Q-1:0]  strip_q
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_token_first_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_sop && cfg_insert |-> tok_done_q);

  assert_token_pad_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tok_done_q) |-> out_valid && (out_data[QUAD_W-1:TOK_W] == '0));

  assert_pass_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !in_sop && !strip_q[idx_q] |=> out_valid && (out_data == $past(in_data)));

  assert_drop_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !in_sop && strip_q[idx_q] |=> !out_valid);
endmodule

bind rxhs_strip_insert rxhs_strip_insert_chk #(
  .QUAD_W (QUAD_W),
  .HDR_Q  (HDR_Q),
  .TOK_W  (ACK_W + TCODE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_insert (cfg_insert),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_sop     (in_sop),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .tok_done_q (tok_done_q),
  .idx_q      (idx_q),
  .strip_q    (strip_q)
);

// File: tb/rxhs_strip_insert_bench.sv
module rxhs_strip_insert_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_insert = 1'b0;
  logic [3:0]  cfg_strip = 4'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic [3:0]  in_ack = 4'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_last;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  rxhs_strip_insert u_rxhs_strip_insert (
    .clk(clk), .rst(rst), .cfg_insert(cfg_insert), .cfg_strip(cfg_strip),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ack(in_ack),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // downstream ready pattern
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected quadlet", {out_last, out_data}, 33'h0);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({out_last, out_data} == e, t, {out_last, out_data}, e);
        end
      end
    end
  end

  task automatic send_pkt(input bit ins, input logic [3:0] strip, input logic [3:0] tc, input int pkt);
    logic [31:0] q[4];
    logic [32:0] seq[5];
    string       tg[5];
    int nq;
    int n;
    logic [3:0] ack;
    nq  = (tc == 4'h0 || tc == 4'h6) ? 4 : 3;
    ack = 4'(pkt * 5 + 3);
    q[0] = {16'hFFC1, 6'(pkt), 2'b01, tc, 4'h0};
    for (int j = 1; j < 4; j++) q[j] = {8'(pkt), 8'(j), 16'h5A00 + 16'(pkt)};
    n = 0;
    if (ins) begin
      seq[n] = {1'b0, 24'h0, ack, tc};
      tg[n]  = "R2/R3 token";
      n++;
    end
    for (int j = 0; j < nq; j++) begin
      if (!strip[j]) begin
        seq[n] = {1'b0, q[j]};
        tg[n]  = (j == 3) ? "R5/R8 payload" : "R4/R8 header";
        n++;
      end
    end
    if (n > 0) begin
      seq[n-1][32] = 1'b1;
      tg[n-1] = {tg[n-1], " R6 last"};
    end
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(seq[k]);
      tag_q.push_back(tg[k]);
    end
    cfg_insert = ins;
    cfg_strip  = strip;
    for (int j = 0; j < nq; j++) begin
      bit first_try;
      first_try = 1'b1;
      if ((pkt % 3) == 1 && j == 1) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = q[j];
      in_sop   = (j == 0);
      in_eop   = (j == nq - 1);
      in_ack   = (j == 0) ? ack : ~ack;
      forever begin
        #1;
        if (first_try && j == 0 && ins)
          chk(in_ready == 1'b0, "R2 stall during token", {32'h0, in_ready}, 33'h0);
        first_try = 1'b0;
        if (in_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
      if (j == 0) begin
        cfg_insert = ~ins;
        cfg_strip  = ~strip;
      end
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  initial begin
    int pkt;
    logic [3:0] codes[4];
    codes[0] = 4'h0; codes[1] = 4'h2; codes[2] = 4'h4; codes[3] = 4'h6;
    pkt = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R1 in reset", {32'h0, out_valid}, 33'h0);
    rst = 1'b0;
    @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R1 after reset", {32'h0, out_valid}, 33'h0);
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      bp_mode = b[0];
      for (int ins = 0; ins < 2; ins++) begin
        for (int s = 0; s < 16; s++) begin
          for (int c = 0; c < 4; c++) begin
            send_pkt(ins[0], 4'(s), codes[c], pkt);
            pkt++;
          end
        end
      end
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all quadlets delivered", 33'(exp_q.size()), 33'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=%0d expected=0 pending", exp_q.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule